// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with Single-Bit Replacement

This block sits between a processor load/store port and a slower word-wide memory. It holds eight 32-bit words as four sets of two ways. A request carries a 32-bit byte address. Bits [3:2] pick the set. Bits [31:4] form the tag that is compared against both ways. Bits [1:0] play no part in a word access. A load that finds its word returns the data with a high hit flag in the same cycle it is presented.

On a load miss the block raises a fetch toward memory and keeps the hit flag low, which stalls the processor. The processor holds the request steady. When memory answers with a one-cycle response-valid pulse, the word is written into the replacement way of the indexed set. The access then completes on the next cycle as an ordinary hit.

Each set has one replacement bit that names the way to evict next. Stores are written through to memory in the cycle they are presented. A store that hits also rewrites the cached word.

The controller has two named states:
- `ST_IDLE` serves lookups and stores. It moves to `ST_FETCH` on a load miss and otherwise stays in `ST_IDLE`.
- `ST_FETCH` holds the memory request. It returns to `ST_IDLE` in the cycle `mem_rvalid` is seen, writing the fill in that same cycle.

Top module: `lru_pair_cache`

## Requirements
- R1: The set index is address bits [3:2], the tag is bits [31:4], and bits [1:0] are ignored. A load to 0x27 after 0x24 is resident hits and returns the word of 0x24.
- R2: A way hits when its valid bit is set and its stored tag equals the address tag; at most one way hits. A load that hits returns the stored word with `rsp_hit` high in the same cycle, with no memory fetch. Way 1 drives the output when it hits, way 0 otherwise.
- R3: After reset every line is invalid and every replacement bit is 0. No memory request is raised while no request is presented, and the first load misses.
- R4: On a load miss, `rsp_hit` stays low and `mem_req` is high with `mem_we` low and `mem_addr` equal to address bits [31:2] until `mem_rvalid`. The returned word is installed, and the held load hits in the following cycle with that word.
- R5: The fill goes to an invalid way if one exists, way 0 first. Otherwise it goes to the way named by the set's replacement bit. So 0x04 and 0x24 (both set 1) reside together, and alternating loads to them hit after the first two misses.
- R6: After any hit or fill, the set's replacement bit names the way not touched. After misses to 0x04, 0x24 and 0x54, 0x04 has been evicted and 0x24 kept. After misses to 0x0C and 0x1C followed by a hit on 0x0C, a miss to 0x2C evicts 0x1C.
- R7: A store that hits rewrites the word in the hit way, reports `rsp_hit` high, and counts as a touch for replacement. In the same cycle it drives `mem_req` and `mem_we` high with `mem_addr` = address bits [31:2] and `mem_wdata` = store data.
- R8: A store that misses reports `rsp_hit` low and is forwarded to memory exactly as in R7, but installs nothing. A later load of that address misses and fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_rdata | output | 32 | Load data, valid when rsp_hit is high |
| rsp_hit | output | 1 | Request found in the cache; a load completes |
| mem_req | output | 1 | Request to next-level memory |
| mem_we | output | 1 | 1 = write-through store, 0 = word fetch |
| mem_addr | output | 30 | Word address (byte address bits [31:2]) |
| mem_wdata | output | 32 | Write-through data |
| mem_rvalid | input | 1 | One-cycle pulse: fetch data present |
| mem_rdata | input | 32 | Fetched word |

## Verification
A store that hits does three things in one cycle: it rewrites the cached word, moves the replacement bit, and forwards the write to memory. The bench issues a store to a resident word and captures the memory port in that cycle. It then reloads the address, expecting the new value with no fetch, and follows with a miss in the same set to confirm the store counted as a touch.

The other coincidence is a fill: it sets the line and flips the replacement bit in the cycle the response arrives. The eviction sequences judge this by which address later costs a fetch.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } lpc_state_e;
endpackage

// File: rtl/lpc_way_array.sv
module lpc_way_array #(
    parameter int SETS   = 4,
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  rd_set,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_set] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set]  <= wr_tag;
            data_q[wr_set] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_set];
    assign rd_tag   = tag_q[rd_set];
    assign rd_data  = data_q[rd_set];

    // R5: a written entry reads back valid with the written word
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_set == wr_set) |=> (rd_valid && rd_data == $past(wr_data)));
endmodule

// File: rtl/lpc_lookup.sv
module lpc_lookup #(
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32,
    parameter int WAYS   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [TAG_W-1:0]             addr_tag,
    input  logic [WAYS-1:0]              way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
    input  logic [WAYS-1:0][DATA_W-1:0]  way_data,
    output logic [WAYS-1:0]              way_hit,
    output logic [DATA_W-1:0]            rdata
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = way_valid[w] && (way_tag[w] == addr_tag);
    end

    // way 1 steers the mux; way 0 is the fallback
    assign rdata = way_hit[1] ? way_data[1] : way_data[0];

    // R2: a tag never lives in both ways of a set
    a_r2_single_way_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));
endmodule

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
    import lpc_pkg::*;
#(
    parameter int SETS = 4,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [SET_W-1:0] req_set,
    input  logic [1:0]       way_hit,
    input  logic [1:0]       way_valid,
    input  logic             mem_rvalid,
    output logic [1:0]       way_we,
    output logic             fill_sel,
    output logic             rsp_hit,
    output logic             mem_req,
    output logic             mem_we
);
    lpc_state_e     state_q, state_d;
    logic [SETS-1:0] use_q;
    logic           victim;
    logic [1:0]     touch;

    always_comb begin
        if (!way_valid[0])      victim = 1'b0;
        else if (!way_valid[1]) victim = 1'b1;
        else                    victim = use_q[req_set];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid && !req_write && !(|way_hit)) state_d = ST_FETCH;
            ST_FETCH: if (mem_rvalid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        way_we   = '0;
        fill_sel = 1'b0;
        rsp_hit  = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        touch    = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    rsp_hit = |way_hit;
                    touch   = way_hit;
                    if (req_write) begin
                        mem_req = 1'b1;
                        mem_we  = 1'b1;
                        way_we  = way_hit;
                    end
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_rvalid) begin
                    fill_sel = 1'b1;
                    way_we   = victim ? 2'b10 : 2'b01;
                    touch    = way_we;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_q <= '0;
        end else if (|touch) begin
            use_q[req_set] <= ~touch[1];
        end
    end

    // R6: a fill leaves the replacement bit naming the other way
    a_r6_fill_flips_use: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && mem_rvalid) |=> (use_q[$past(req_set)] == ~$past(victim)));

    // R4: a fetch ends in idle
    a_r4_fetch_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && mem_rvalid) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/lru_pair_cache.sv
module lru_pair_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 4,
    parameter int OFF_W  = 2,
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - SET_W - OFF_W,
    localparam int WA_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_hit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int WAYS = 2;

    logic [SET_W-1:0]             set_idx;
    logic [TAG_W-1:0]             addr_tag;
    logic [WAYS-1:0]              w_valid, w_hit, w_we;
    logic [WAYS-1:0][TAG_W-1:0]   w_tag;
    logic [WAYS-1:0][DATA_W-1:0]  w_data;
    logic                         fill_sel;
    logic [DATA_W-1:0]            wr_word;

    assign set_idx   = req_addr[OFF_W +: SET_W];
    assign addr_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign wr_word   = fill_sel ? mem_rdata : req_wdata;
    assign mem_addr  = req_addr[ADDR_W-1:OFF_W];
    assign mem_wdata = req_wdata;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        lpc_way_array #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_arr (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_set  (set_idx),
            .rd_valid(w_valid[w]),
            .rd_tag  (w_tag[w]),
            .rd_data (w_data[w]),
            .wr_en   (w_we[w]),
            .wr_set  (set_idx),
            .wr_tag  (addr_tag),
            .wr_data (wr_word)
        );
    end

    lpc_lookup #(.TAG_W(TAG_W), .DATA_W(DATA_W), .WAYS(WAYS)) u_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_tag (addr_tag),
        .way_valid(w_valid),
        .way_tag  (w_tag),
        .way_data (w_data),
        .way_hit  (w_hit),
        .rdata    (rsp_rdata)
    );

    lpc_ctrl #(.SETS(SETS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_set   (set_idx),
        .way_hit   (w_hit),
        .way_valid (w_valid),
        .mem_rvalid(mem_rvalid),
        .way_we    (w_we),
        .fill_sel  (fill_sel),
        .rsp_hit   (rsp_hit),
        .mem_req   (mem_req),
        .mem_we    (mem_we)
    );

    // R4: the processor never sees a hit while a fetch is outstanding
    a_r4_stall_during_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !rsp_hit);

    // R4: a held load completes right after its fill
    a_r4_hit_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_sel && req_valid && !req_write) |=>
            ((req_valid && !req_write && $stable(req_addr)) |-> rsp_hit));

    // R8: a store miss installs nothing
    a_r8_store_miss_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !rsp_hit) |-> (w_we == '0));

    // R7: a store is forwarded to memory in its own cycle
    a_r7_store_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !(mem_req && !mem_we)) |-> (mem_req && mem_we));
endmodule

// File: tb/lru_pair_cache_test.sv
module lru_pair_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_hit, mem_req, mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    lru_pair_cache uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_hit(rsp_hit), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] data;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    // next-level memory model
    logic [31:0] over [logic [29:0]];
    int          fetch_cnt = 0;
    logic        busy = 1'b0;
    int          cnt = 0;
    logic [29:0] pend = '0;

    function automatic logic [31:0] model_read(logic [29:0] a);
        if (over.exists(a)) return over[a];
        return {2'b10, a} ^ 32'h5A5A_3C3C;
    endfunction

    task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", r, act, expv);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            mem_rvalid <= 1'b0;
        end else if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
        end else if (busy) begin
            if (cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= model_read(pend);
                busy       <= 1'b0;
                fetch_cnt  = fetch_cnt + 1;
            end else begin
                cnt = cnt - 1;
            end
        end else if (mem_req && !mem_we) begin
            busy <= 1'b1;
            cnt = 1;
            pend <= mem_addr;
        end
        if (rst_n && mem_req && mem_we) over[mem_addr] = mem_wdata;
    end

    // monitor: compares each completed load against the scoreboard
    always @(negedge clk) begin
        if (rst_n && req_valid && !req_write && rsp_hit) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected completion", rsp_rdata, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_rdata == e.data, e.req, rsp_rdata, e.data);
            end
        end
    end

    task automatic do_load(logic [31:0] addr, int exp_fetch, string r);
        int f0, stall;
        exp_t e;
        e.data = model_read(addr[31:2]);
        e.req  = r;
        exp_q.push_back(e);
        f0 = fetch_cnt;
        stall = 0;
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = addr;
        forever begin
            @(negedge clk);
            if (rsp_hit) break;
            if (stall == 0)
                chk(mem_req == 1'b0 || mem_we == 1'b0, {r, " R4 no write on miss"}, 32'(mem_we), 0);
            stall++;
            if (stall > 50) break;
        end
        chk((fetch_cnt - f0) == exp_fetch, {r, " fetch count"}, 32'(fetch_cnt - f0), 32'(exp_fetch));
        if (exp_fetch == 0) chk(stall == 0, {r, " R2 same-cycle hit"}, 32'(stall), 0);
        else                chk(stall > 0, {r, " R4 stall on miss"}, 32'(stall), 1);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic do_store(logic [31:0] addr, logic [31:0] d, bit exp_hit, string r);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = addr; req_wdata = d;
        @(negedge clk);
        chk(rsp_hit == exp_hit, {r, " hit flag"}, 32'(rsp_hit), 32'(exp_hit));
        chk(mem_req && mem_we, {r, " forwarded"}, {30'd0, mem_req, mem_we}, 32'd3);
        chk(mem_addr == addr[31:2], {r, " address"}, {2'b0, mem_addr}, {2'b0, addr[31:2]});
        chk(mem_wdata == d, {r, " data"}, mem_wdata, d);
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R3: idle after reset, no memory traffic
        chk(mem_req == 1'b0, "R3 idle mem_req", 32'(mem_req), 0);
        chk(rsp_hit == 1'b0, "R3 idle hit", 32'(rsp_hit), 0);

        // R3/R4/R5: first loads to set 1 miss, then share the set
        do_load(32'h04, 1, "R3 first load misses");
        do_load(32'h24, 1, "R5 second way filled");
        do_load(32'h04, 0, "R5 alternate hit 0x04");
        do_load(32'h24, 0, "R5 alternate hit 0x24");
        do_load(32'h04, 0, "R5 alternate hit 0x04 again");
        do_load(32'h24, 0, "R2 way-1 hit data");
        // now replacement bit names way 0 (0x04)
        do_load(32'h54, 1, "R6 0x54 misses");
        do_load(32'h24, 0, "R6 0x24 kept");
        do_load(32'h04, 1, "R6 0x04 evicted");

        // R1: byte offset ignored
        do_load(32'h27, 0, "R1 byte offset ignored");

        // R6: hit moves the replacement bit (set 3)
        do_load(32'h0C, 1, "R6 fill 0x0C");
        do_load(32'h1C, 1, "R6 fill 0x1C");
        do_load(32'h0C, 0, "R6 hit 0x0C");
        do_load(32'h2C, 1, "R6 miss 0x2C");
        do_load(32'h0C, 0, "R6 0x0C kept after hit");
        do_load(32'h1C, 1, "R6 0x1C evicted");

        // R7: store hit updates cache and forwards; counts as a touch
        // set 3 now: 0x1C way1 just filled, 0x0C in way0 -> use names way0
        do_store(32'h1C, 32'hDEAD_BEEF, 1'b1, "R7 store hit");
        do_load(32'h1C, 0, "R7 reload sees stored word");
        do_store(32'h0C, 32'h1234_5678, 1'b1, "R7 store hit way0");
        do_load(32'h3C, 1, "R7 store touch moved victim");
        do_load(32'h0C, 0, "R7 0x0C kept after store touch");

        // R8: store miss forwards but does not allocate
        do_store(32'h38, 32'hCAFE_F00D, 1'b0, "R8 store miss");
        do_load(32'h38, 1, "R8 no allocation on store miss");
        do_load(32'h38, 0, "R8 filled after load");

        // R1: high tag bits distinguish lines
        do_load(32'h8000_0004, 1, "R1 tag high bit differs");

        repeat (2) @(posedge clk);
        chk(exp_q.size() == 0, "R2 scoreboard drained", 32'(exp_q.size()), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule